// File: doc/BRIEF.md
# Keyed Watchdog Timer with Check-Bit Guard

This block watches for software that has stopped running. A free-running timebase divides the oscillator clock by a fixed base factor, then by a prescale factor picked with a 3-bit field, and drives an 8-bit up-counter. If the counter runs past its top value, the block raises a fixed-length pulse. Software keeps the counter away from overflow by writing a two-step key sequence through a small write port. The counter then clears and the timebase restarts.

A control write carries an interrupt-routing bit, a halt bit, a 3-bit guard field and the prescale select. The guard field must hold binary 101 on every control write. A control write with any other guard value is treated as corrupted software. It fires the pulse at once and leaves the stored settings unchanged. The pulse goes to the reset line, or to the interrupt line when routing to interrupt is selected. Both lines sit in the oscillator clock domain.

Top module: `wdg_keyed_top`

## Requirements
- R1: The count advances once every BASE_DIV × D oscillator cycles. D is set by the prescale select field: 1 for select values 0 and 1, and 2^(s−1) for a select value s from 2 to 7.
- R2: The counter is CNT_W bits wide and advances by one per timebase tick. A tick that arrives while the counter holds its all-ones value fires the pulse, and the counter wraps to zero. From a restart, the first pulse appears 2^CNT_W × BASE_DIV × D cycles after the restarting edge.
- R3: A key write (wr_ctrl = 0) of 0x55 arms the sequence. A following key write of 0xAA clears the counter and restarts the timebase on the edge that captures it. A 0xAA that is not preceded by an arming write does not clear. Any other value disarms. A repeated 0x55 keeps the sequence armed.
- R4: A control write (wr_ctrl = 1) uses these fields: bit 7 routes to interrupt, bit 6 halts, bits 5:3 form the guard, and bits 2:0 form the prescale select. When the guard is 101, the write stores the fields and restarts the counter and timebase. When the guard is any other value, the pulse starts on the capturing edge and the stored fields are not changed.
- R5: While the halt bit is set, the counter holds and no overflow pulse is produced. A control write with a bad guard still fires the pulse.
- R6: When the routing bit is 0, the pulse appears on wdog_rst. When it is 1, the pulse appears on wdog_irq. The two lines are never high together.
- R7: Each pulse lasts exactly PULSE_LEN oscillator cycles. A firing event that arrives while a pulse is in progress neither extends that pulse nor starts a new one.
- R8: After reset, both outputs are low, the counter is zero, the watchdog is running with prescale select 0, and routing goes to the reset line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_ctrl | input | 1 | 1 selects a control write, 0 selects a key write |
| wr_data | input | 8 | Write data |
| wdog_rst | output | 1 | Reset-line pulse |
| wdog_irq | output | 1 | Interrupt-line pulse |

## Verification
Every internal fault in this block shows up as a pulse that is wrongly timed, wrongly routed or wrongly sized at the two output lines. A corrupted timebase or counter moves the first pulse away from its exact expected cycle, so the distance from the last restart to the pulse edge is measured to the cycle. A fault in the key sequencer only becomes visible at the next overflow, up to a full counter period after the key writes, so each key scenario waits for that overflow. Guard decoding and pulse routing faults appear on the edge right after the write, and a pulse-length fault appears within PULSE_LEN cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef struct packed {
    logic       to_irq;
    logic       halt;
    logic [2:0] guard;
    logic [2:0] psel;
  } wdg_ctrl_t;

  localparam logic [2:0] GUARD_OK = 3'b101;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic {
    KS_IDLE,
    KS_ARMED
  } key_state_e;

endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase #(
  parameter int BASE_DIV = 512,
  parameter int PS_W     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [PS_W-1:0] psel,
  output logic            tick
);
  localparam int BW     = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int MAX_SH = (1 << PS_W) - 2;
  localparam int PW     = (MAX_SH > 0) ? MAX_SH : 1;

  logic [BW-1:0] base_q;
  logic          base_hit;
  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_lim;

  assign base_hit = (base_q == BW'(BASE_DIV - 1));

  // Prescale limit: select 0 and 1 divide by one, select s divides by 2^(s-1).
  always_comb begin
    if (psel <= PS_W'(1)) pre_lim = '0;
    else                  pre_lim = (PW'(1) << (psel - PS_W'(1))) - PW'(1);
  end

  assign tick = base_hit && (pre_q >= pre_lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (base_hit) begin
      base_q <= '0;
      pre_q  <= (pre_q >= pre_lim) ? '0 : pre_q + PW'(1);
    end else begin
      base_q <= base_q + BW'(1);
    end
  end

  generate
    if (BASE_DIV > 1) begin : g_gap
      // R1: the base stage never ticks on two cycles in a row
      p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/wdg_keyseq.sv
module wdg_keyseq #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  output logic             kick
);
  import wdg_pkg::*;

  key_state_e state_q;

  assign kick = key_wr && (state_q == KS_ARMED) && (key_val == KEY_W'(KEY_FIRE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_IDLE;
    end else if (key_wr) begin
      if (key_val == KEY_W'(KEY_ARM)) state_q <= KS_ARMED;
      else                            state_q <= KS_IDLE;
    end
  end

  // R3: a completed sequence always leaves the sequencer disarmed
  p_disarm_after_kick_r3: assert property (@(posedge clk) disable iff (rst)
    kick |=> (state_q == KS_IDLE));

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int PULSE_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic to_irq,
  output logic line_rst,
  output logic line_irq,
  output logic busy
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] left_q;

  assign busy = line_rst || line_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      line_rst <= 1'b0;
      line_irq <= 1'b0;
    end else if (!busy) begin
      if (fire) begin
        left_q   <= CW'(PULSE_LEN - 1);
        line_rst <= !to_irq;
        line_irq <= to_irq;
      end
    end else if (left_q == '0) begin
      line_rst <= 1'b0;
      line_irq <= 1'b0;
    end else begin
      left_q <= left_q - CW'(1);
    end
  end

  // R6: the pulse is never on both lines
  p_lines_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(line_rst && line_irq));

  generate
    if (PULSE_LEN > 1) begin : g_hold
      // R7: a pulse that has started keeps going for its next cycle
      p_pulse_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);
    end
  endgenerate

endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top #(
  parameter int BASE_DIV  = 512,
  parameter int PULSE_LEN = 512,
  parameter int CNT_W     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_data,
  output logic       wdog_rst,
  output logic       wdog_irq
);
  import wdg_pkg::*;

  localparam int PS_W = $bits(wr_data) - 5;

  wdg_ctrl_t        ctrl_q;
  wdg_ctrl_t        wr_fields;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr, key_wr, guard_bad, ctrl_ok;
  logic             kick, restart, tick, overflow, fire, busy;

  assign wr_fields = wdg_ctrl_t'(wr_data);
  assign ctrl_wr   = wr_en && wr_ctrl;
  assign key_wr    = wr_en && !wr_ctrl;
  assign guard_bad = ctrl_wr && (wr_fields.guard != GUARD_OK);
  assign ctrl_ok   = ctrl_wr && !guard_bad;
  assign restart   = ctrl_ok || kick;
  assign overflow  = tick && !ctrl_q.halt && (cnt_q == '1) && !restart;
  assign fire      = guard_bad || overflow;

  wdg_timebase #(.BASE_DIV(BASE_DIV), .PS_W(PS_W)) u_timebase (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .psel    (ctrl_q.psel),
    .tick    (tick)
  );

  wdg_keyseq #(.KEY_W(8)) u_keyseq (
    .clk     (clk),
    .rst     (rst),
    .key_wr  (key_wr),
    .key_val (wr_data),
    .kick    (kick)
  );

  wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .to_irq   (ctrl_q.to_irq),
    .line_rst (wdog_rst),
    .line_irq (wdog_irq),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{to_irq: 1'b0, halt: 1'b0, guard: GUARD_OK, psel: '0};
    end else if (ctrl_ok) begin
      ctrl_q <= wr_fields;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart)             cnt_q <= '0;
    else if (tick && !ctrl_q.halt)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R3: the key sequencer's clear reaches the counter on the same edge
  p_key_clears_r3: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == '0));

  // R4: a bad guard on an idle pulse stage shows on a line next cycle
  p_bad_guard_fires_r4: assert property (@(posedge clk) disable iff (rst)
    (guard_bad && !busy) |=> (wdog_rst || wdog_irq));

  // R5: a halted counter does not move unless restarted
  p_halt_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.halt && !restart) |=> $stable(cnt_q));

endmodule

// File: tb/wdg_keyed_top_bench.sv
module wdg_keyed_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BD  = 4;
  localparam int PL  = 8;
  localparam int LIM = 256 * BD;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic        irq;
    logic [31:0] span;
  } vec_t;

  // control byte, expected line (1 = interrupt), cycles to first pulse
  localparam vec_t VECS [4] = '{
    '{8'h28, 1'b0, 32'(LIM)},
    '{8'h29, 1'b0, 32'(LIM)},
    '{8'hAA, 1'b1, 32'(LIM * 2)},
    '{8'hAB, 1'b1, 32'(LIM * 4)}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] wr_data = '0;
  logic wdog_rst, wdog_irq;
  int checks = 0, errors = 0;
  int unsigned cyc = 0, wr_cyc = 0;

  wdg_keyed_top #(.BASE_DIV(BD), .PULSE_LEN(PL), .CNT_W(8)) u_wdg_keyed_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
    .wr_data(wr_data), .wdog_rst(wdog_rst), .wdog_irq(wdog_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit c, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ctrl = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic wait_fire(input int unsigned ref_cyc, input int unsigned maxc,
                           output int dt);
    while (!(wdog_rst || wdog_irq) && (cyc - ref_cyc) < maxc) @(negedge clk);
    dt = int'(cyc - ref_cyc);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (wdog_rst || wdog_irq) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdog_rst || wdog_irq) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog timeout actual %0d expected 0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dt, n, rise;
    int unsigned t0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wr_cyc = cyc;
    // R8: reset state
    chk(!wdog_rst && !wdog_irq, "R8 outputs low after reset", wdog_rst + wdog_irq, 0);
    wait_fire(wr_cyc, 2 * LIM, dt);
    chk(dt == LIM, "R8 R2 default period from reset", dt, LIM);
    chk(wdog_rst && !wdog_irq, "R8 default routing to reset", wdog_irq, 0);
    pulse_len(n);
    chk(n == PL, "R7 pulse length", n, PL);

    // Table walk: R1 prescale, R4 valid write restarts, R6 routing
    for (int i = 0; i < 4; i++) begin
      wr(1'b1, VECS[i].ctrl);
      wait_fire(wr_cyc, 2 * VECS[i].span, dt);
      chk(dt == int'(VECS[i].span), "R1 R4 period after control write", dt, int'(VECS[i].span));
      chk(wdog_irq == VECS[i].irq && wdog_rst == !VECS[i].irq, "R6 pulse line",
          wdog_irq, VECS[i].irq);
      pulse_len(n);
      chk(n == PL, "R7 pulse length in table", n, PL);
    end

    // R3: full key sequence restarts the period
    wr(1'b1, 8'h28);
    repeat (600) @(negedge clk);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'hAA);
    wait_fire(wr_cyc, 2 * LIM, dt);
    chk(dt == LIM, "R3 key sequence clears counter", dt, LIM);
    pulse_len(n);

    // R3: repeated arm value keeps the sequence armed
    wr(1'b1, 8'h28);
    repeat (300) @(negedge clk);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'hAA);
    wait_fire(wr_cyc, 2 * LIM, dt);
    chk(dt == LIM, "R3 repeated arm then fire clears", dt, LIM);
    pulse_len(n);

    // R3: interrupted sequence and lone fire value do not clear
    wr(1'b1, 8'h28);
    t0 = wr_cyc;
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h12);
    wr(1'b0, 8'hAA);
    repeat (100) @(negedge clk);
    wr(1'b0, 8'hAA);
    wait_fire(t0, 2 * LIM, dt);
    chk(dt == LIM, "R3 broken sequence leaves counter", dt, LIM);
    pulse_len(n);

    // R4: bad guard fires at once; R7: second firing during pulse ignored
    wr(1'b1, 8'h08);
    chk(wdog_rst && !wdog_irq, "R4 bad guard fires next edge", wdog_rst, 1);
    rise = int'(cyc);
    wr(1'b1, 8'h10);
    while (wdog_rst || wdog_irq) @(negedge clk);
    chk(int'(cyc) - rise == PL, "R7 pulse not extended", int'(cyc) - rise, PL);
    quiet(20, "R7 no retrigger after pulse");

    // R5: halt stops overflow pulses
    wr(1'b1, 8'h68);
    quiet(3 * LIM, "R5 halted watchdog stays quiet");
    wr(1'b1, 8'h00);
    chk(wdog_rst && !wdog_irq, "R5 bad guard fires while halted", wdog_rst, 1);
    pulse_len(n);
    chk(n == PL, "R7 pulse length while halted", n, PL);
    // R4: the bad write did not clear the halt bit
    quiet(2 * LIM, "R4 bad guard leaves fields unchanged");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule